// File: doc/BRIEF.md
# Register-Driven Multiply-Accumulate Unit

This block is a small multiplier peripheral that sits on a simple synchronous register bus. Software loads two 16-bit operands and reads a 48-bit accumulator split across three 16-bit words. No start command exists. An operation launches when operands are written, according to the mode bits in an 8-bit control register. The available operations are product, product added to the accumulator, product subtracted from the accumulator, negated product, and squaring. Each operation can treat the operands as signed or as unsigned.

The bus accepts one access per cycle. It has no handshake and no back-pressure: a write is taken in the cycle it is presented. Reads are combinational from the register state. A triggering write is sampled at clock edge T. The arithmetic is committed at edge T+1, and the new accumulator and flag are readable from that point on. Software must therefore leave one cycle between the triggering write and the read of the result.

Register addresses: 0 is control, 1 is operand A, 2 is operand B, 3 is accumulator bits 15:0, 4 is bits 31:16, and 5 is bits 47:32. Other addresses read 0. Control bits: 7 is the overflow flag (read-only); 6 holds the accumulator unchanged; 5 is the clear command (self-clearing); 4 selects square; 3 selects single-load triggering; 2 selects negate/subtract; 1 selects accumulate; 0 selects unsigned.

Top module: `mac_unit`

## Requirements
- R1: After reset every register (control, both operands, all three accumulator words) reads 0, and unmapped addresses 6 and 7 read 0.
- R2: With square (bit 4) and single-load (bit 3) both 0, a write to only one operand starts nothing and the accumulator is unchanged. The operation starts when both A and B have been written since the last operation. The record of loaded operands empties after each operation.
- R3: With single-load (bit 3) set and square clear, every write to A or B starts an operation using the other operand's stored value.
- R4: With square (bit 4) set, a write to A or B puts the value in both operands and starts a square operation, whatever bit 3 holds.
- R5: With accumulate (bit 1) and negate (bit 2) both 0, the accumulator takes the product. In signed mode (bit 0 = 0) the product is sign-extended to 48 bits; in unsigned mode it is zero-extended. The accumulator still holds its old value between edge T and edge T+1.
- R6: With accumulate (bit 1) set, the product is added to the accumulator, or subtracted from it when bit 2 is set, with 48-bit wraparound.
- R7: With bit 2 set and bit 1 clear, a signed operation stores the negated product. An unsigned operation stores the plain product and sets the overflow flag.
- R8: The overflow flag (bit 7) is set when an accumulate or subtract leaves the range of 48-bit two's complement (signed) or 0..2^48-1 (unsigned). Every new operation replaces the flag with its own outcome.
- R9: With bit 6 set, an operation leaves the accumulator unchanged but still updates the overflow flag.
- R10: Writing control with bit 5 set zeroes both operands, the accumulator, the overflow flag and the record of loaded operands; bit 5 reads back 0. Writing bit 5 as 0 clears nothing, and bit 7 cannot be written.
- R11: A write to the control register starts no operation and changes neither the accumulator nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |

## Verification
The bench goes after the trigger rules first. A design that fires on the first operand under two-operand loading, or that keeps the load record across operations, shows a product too early or too late. The sign handling is tested with operands of 0x8000 and 0xFFFF in both modes, so a design that sign-extends unsigned products or zero-extends signed ones gives wrong upper accumulator words. The bench also forces unsigned borrow and carry out of the accumulator and uses the unsigned negate request, checking that the flag is set there and cleared by the next operation. Finally, it checks that a held accumulator still updates the flag and that the clear command reaches the operands; a design that missed either would leave a stale operand or a stale flag visible at the ports.

// File: rtl/mac_pkg.sv
package mac_pkg;

  localparam int ADR_CTRL     = 0;
  localparam int ADR_OPA      = 1;
  localparam int ADR_OPB      = 2;
  localparam int ADR_ACC_BASE = 3;

  // control register bit positions (software visible)
  localparam int BIT_UNS    = 0;
  localparam int BIT_ACCUM  = 1;
  localparam int BIT_NEG    = 2;
  localparam int BIT_SINGLE = 3;
  localparam int BIT_SQUARE = 4;
  localparam int BIT_CLEAR  = 5;
  localparam int BIT_HOLD   = 6;
  localparam int BIT_OVF    = 7;

  typedef struct packed {
    logic hold_acc;
    logic square;
    logic single_load;
    logic negate;
    logic accumulate;
    logic unsigned_op;
  } mac_cfg_t;

endpackage

// File: rtl/mac_seq.sv
module mac_seq
  import mac_pkg::*;
#(
  parameter int OP_W   = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [OP_W-1:0]   wdata,
  output mac_cfg_t          cfg,
  output logic [OP_W-1:0]   opa,
  output logic [OP_W-1:0]   opb,
  output logic              go,
  output logic              clr
);

  logic wr_ctrl, wr_a, wr_b;
  logic seen_a, seen_b;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(ADR_CTRL));
  assign wr_a    = wr_en && (addr == ADDR_W'(ADR_OPA));
  assign wr_b    = wr_en && (addr == ADDR_W'(ADR_OPB));
  assign clr     = wr_ctrl && wdata[BIT_CLEAR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      opa    <= '0;
      opb    <= '0;
      seen_a <= 1'b0;
      seen_b <= 1'b0;
      go     <= 1'b0;
    end else begin
      go <= 1'b0;
      if (wr_ctrl) begin
        cfg.hold_acc    <= wdata[BIT_HOLD];
        cfg.square      <= wdata[BIT_SQUARE];
        cfg.single_load <= wdata[BIT_SINGLE];
        cfg.negate      <= wdata[BIT_NEG];
        cfg.accumulate  <= wdata[BIT_ACCUM];
        cfg.unsigned_op <= wdata[BIT_UNS];
        if (wdata[BIT_CLEAR]) begin
          opa    <= '0;
          opb    <= '0;
          seen_a <= 1'b0;
          seen_b <= 1'b0;
        end
      end else if (wr_a || wr_b) begin
        if (cfg.square) begin
          opa    <= wdata;
          opb    <= wdata;
          go     <= 1'b1;
          seen_a <= 1'b0;
          seen_b <= 1'b0;
        end else begin
          if (wr_a) opa <= wdata;
          else      opb <= wdata;
          if (cfg.single_load || (wr_a ? seen_b : seen_a)) begin
            go     <= 1'b1;
            seen_a <= 1'b0;
            seen_b <= 1'b0;
          end else if (wr_a) begin
            seen_a <= 1'b1;
          end else begin
            seen_b <= 1'b1;
          end
        end
      end
    end
  end

  a_r10_clear_operands: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (opa == '0) && (opb == '0) && !go);

  a_r11_ctrl_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> !go);

  a_r4_square_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_a || wr_b) && cfg.square) |=> (opa == opb) && go);

  a_r3_single_starts: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_a || wr_b) && cfg.single_load) |=> go);

  a_r2_first_load_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && !seen_b && !cfg.single_load && !cfg.square) |=> !go && seen_a);

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int OP_W      = 16,
  parameter int ACC_WORDS = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      go,
  input  logic                      clr,
  input  mac_cfg_t                  cfg,
  input  logic [OP_W-1:0]           opa,
  input  logic [OP_W-1:0]           opb,
  output logic [OP_W*ACC_WORDS-1:0] acc,
  output logic                      ovf
);

  localparam int PROD_W = 2 * OP_W;
  localparam int ACC_W  = OP_W * ACC_WORDS;
  localparam int EXT_W  = ACC_W - PROD_W;

  logic signed [PROD_W-1:0] prod_s;
  logic        [PROD_W-1:0] prod_u;
  logic        [ACC_W-1:0]  prod_ext;
  logic        [ACC_W:0]    wide_sum;
  logic        [ACC_W-1:0]  nxt_acc;
  logic                     nxt_ovf;
  logic                     sgn_a, sgn_p, sgn_r;

  assign prod_s = $signed(opa) * $signed(opb);
  assign prod_u = opa * opb;

  generate
    if (EXT_W > 0) begin : g_ext
      assign prod_ext = cfg.unsigned_op ? {{EXT_W{1'b0}}, prod_u}
                                        : {{EXT_W{prod_s[PROD_W-1]}}, prod_s};
    end else begin : g_noext
      assign prod_ext = cfg.unsigned_op ? prod_u[ACC_W-1:0] : prod_s[ACC_W-1:0];
    end
  endgenerate

  assign wide_sum = cfg.negate ? ({1'b0, acc} - {1'b0, prod_ext})
                               : ({1'b0, acc} + {1'b0, prod_ext});
  assign sgn_a = acc[ACC_W-1];
  assign sgn_p = prod_ext[ACC_W-1];
  assign sgn_r = wide_sum[ACC_W-1];

  always_comb begin
    if (cfg.accumulate) begin
      nxt_acc = wide_sum[ACC_W-1:0];
      if (cfg.unsigned_op)
        nxt_ovf = wide_sum[ACC_W];
      else if (cfg.negate)
        nxt_ovf = (sgn_a != sgn_p) && (sgn_r != sgn_a);
      else
        nxt_ovf = (sgn_a == sgn_p) && (sgn_r != sgn_a);
    end else if (cfg.negate && !cfg.unsigned_op) begin
      nxt_acc = '0 - prod_ext;
      nxt_ovf = 1'b0;
    end else begin
      nxt_acc = prod_ext;
      nxt_ovf = cfg.negate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      ovf <= 1'b0;
    end else if (clr) begin
      acc <= '0;
      ovf <= 1'b0;
    end else if (go) begin
      ovf <= nxt_ovf;
      if (!cfg.hold_acc) acc <= nxt_acc;
    end
  end

  a_r10_clear_acc: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0) && !ovf);

  a_r9_hold_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !clr && cfg.hold_acc) |=> $stable(acc));

  a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !clr) |=> $stable(acc) && $stable(ovf));

  a_r7_unsigned_negate_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !clr && cfg.unsigned_op && cfg.negate && !cfg.accumulate) |=> ovf);

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OP_W      = 16,
  parameter int ACC_WORDS = 3,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [OP_W-1:0]   bus_wdata,
  output logic [OP_W-1:0]   bus_rdata
);

  localparam int ACC_W = OP_W * ACC_WORDS;

  mac_cfg_t         cfg;
  logic [OP_W-1:0]  opa, opb;
  logic             go, clr, ovf;
  logic [ACC_W-1:0] acc;

  mac_seq #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .cfg   (cfg),
    .opa   (opa),
    .opb   (opb),
    .go    (go),
    .clr   (clr)
  );

  mac_datapath #(.OP_W(OP_W), .ACC_WORDS(ACC_WORDS)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .clr   (clr),
    .cfg   (cfg),
    .opa   (opa),
    .opb   (opb),
    .acc   (acc),
    .ovf   (ovf)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADR_CTRL)) begin
      bus_rdata[BIT_OVF]    = ovf;
      bus_rdata[BIT_HOLD]   = cfg.hold_acc;
      bus_rdata[BIT_SQUARE] = cfg.square;
      bus_rdata[BIT_SINGLE] = cfg.single_load;
      bus_rdata[BIT_NEG]    = cfg.negate;
      bus_rdata[BIT_ACCUM]  = cfg.accumulate;
      bus_rdata[BIT_UNS]    = cfg.unsigned_op;
    end else if (bus_addr == ADDR_W'(ADR_OPA)) begin
      bus_rdata = opa;
    end else if (bus_addr == ADDR_W'(ADR_OPB)) begin
      bus_rdata = opb;
    end else begin
      for (int w = 0; w < ACC_WORDS; w++) begin
        if (bus_addr == ADDR_W'(ADR_ACC_BASE + w)) bus_rdata = acc[w*OP_W +: OP_W];
      end
    end
  end

endmodule

// File: tb/mac_unit_bench.sv
module mac_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model state
  logic [7:0]  m_cfg = '0;
  logic [15:0] m_a = '0, m_b = '0;
  logic [47:0] m_acc = '0;
  logic        m_of = 1'b0;
  logic        s_a = 1'b0, s_b = 1'b0;

  always #5 clk = ~clk;

  mac_unit u_mac_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // expected result of one operation, from the requirements
  task automatic model_compute();
    longint pa, pb, prod, accv, s, lim;
    logic uns, neg, mac;
    logic [47:0] res;
    logic of;
    uns = m_cfg[0]; mac = m_cfg[1]; neg = m_cfg[2];
    pa = uns ? longint'({48'd0, m_a}) : longint'($signed(m_a));
    pb = uns ? longint'({48'd0, m_b}) : longint'($signed(m_b));
    prod = pa * pb;
    if (mac) begin
      accv = uns ? longint'({16'd0, m_acc}) : longint'($signed(m_acc));
      s = neg ? accv - prod : accv + prod;
      lim = longint'(1) <<< 47;
      if (uns) of = (s < 0) || (s >= (lim * 2));
      else     of = (s >= lim) || (s < -lim);
      res = s[47:0];
    end else if (neg && !uns) begin
      s = -prod; res = s[47:0]; of = 1'b0;
    end else begin
      res = prod[47:0]; of = neg;
    end
    m_of = of;
    if (!m_cfg[6]) m_acc = res;
  endtask

  task automatic model_write(input logic [2:0] a, input logic [15:0] d);
    if (a == 3'd0) begin
      m_cfg = d[7:0] & 8'h5F;
      if (d[5]) begin
        m_a = '0; m_b = '0; m_acc = '0; m_of = 1'b0; s_a = 1'b0; s_b = 1'b0;
      end
    end else if (a == 3'd1 || a == 3'd2) begin
      if (m_cfg[4]) begin
        m_a = d; m_b = d; s_a = 1'b0; s_b = 1'b0; model_compute();
      end else begin
        if (a == 3'd1) m_a = d; else m_b = d;
        if (m_cfg[3] || (a == 3'd1 ? s_b : s_a)) begin
          s_a = 1'b0; s_b = 1'b0; model_compute();
        end else if (a == 3'd1) s_a = 1'b1;
        else s_b = 1'b1;
      end
    end
  endtask

  // write; one idle cycle follows so that the result is committed
  task automatic wr(input logic [2:0] a, input logic [15:0] d, input bit peek);
    logic [47:0] old_acc;
    logic [15:0] v;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    old_acc = m_acc;
    model_write(a, d);
    if (peek) begin
      rd(3'd3, v); check("R5 result not before next edge", v, old_acc[15:0]);
    end
    @(negedge clk);
  endtask

  task automatic check_state(input string req);
    logic [15:0] v;
    rd(3'd3, v); check(req, v, m_acc[15:0]);
    rd(3'd4, v); check(req, v, m_acc[31:16]);
    rd(3'd5, v); check(req, v, m_acc[47:32]);
    rd(3'd0, v); check(req, v, {8'h00, m_of, m_cfg[6:0]});
  endtask

  function automatic logic [15:0] pick(input int unsigned r);
    case (r % 8)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      default: return 16'($urandom());
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); check("R1 reset value", v, 16'h0000);
    end

    // R2 two-operand load, signed
    wr(3'd0, 16'h0000, 0);
    wr(3'd1, 16'h0003, 0);
    check_state("R2 one operand waits");
    wr(3'd2, 16'hFFFB, 0);
    check_state("R2 both operands start");
    check("R5 signed extension", m_acc[47:32], 16'hFFFF);
    wr(3'd1, 16'h0002, 0);
    check_state("R2 load record cleared");
    wr(3'd2, 16'h0004, 1);
    check_state("R5 product after one cycle");

    // R3 single-load
    wr(3'd0, 16'h0008, 0);
    wr(3'd1, 16'h8000, 0);
    check_state("R3 single write starts");
    wr(3'd0, 16'h0009, 0);
    wr(3'd2, 16'hFFFF, 0);
    check_state("R5 unsigned zero extension");

    // R4 square overrides both load rules
    wr(3'd0, 16'h0010, 0);
    wr(3'd2, 16'hFFF0, 0);
    check_state("R4 square signed");
    rd(3'd1, v); check("R4 operand mirror", v, 16'hFFF0);
    wr(3'd0, 16'h0013, 0);
    wr(3'd1, 16'hFFFF, 0);
    check_state("R4 square accumulate unsigned");

    // R6 accumulate / subtract
    wr(3'd0, 16'h000A, 0);
    wr(3'd1, 16'h1234, 0);
    wr(3'd2, 16'h8001, 0);
    check_state("R6 accumulate add");
    wr(3'd0, 16'h000E, 0);
    wr(3'd1, 16'h7FFF, 0);
    check_state("R6 accumulate subtract");

    // R7 negate
    wr(3'd0, 16'h000C, 0);
    wr(3'd1, 16'h0005, 0);
    check_state("R7 signed negate");
    wr(3'd0, 16'h000D, 0);
    wr(3'd1, 16'h0005, 0);
    check_state("R7 unsigned negate flags");
    check("R7 flag set", {15'd0, m_of}, 16'h0001);

    // R8 unsigned borrow then carry, then flag cleared
    wr(3'd0, 16'h0020, 0);
    wr(3'd0, 16'h000F, 0);
    wr(3'd1, 16'h0001, 0);
    wr(3'd2, 16'h0001, 0);
    check_state("R8 unsigned borrow");
    wr(3'd0, 16'h000B, 0);
    wr(3'd1, 16'h0001, 0);
    check_state("R8 unsigned carry");
    wr(3'd0, 16'h0008, 0);
    wr(3'd1, 16'h0002, 0);
    check_state("R8 flag replaced");

    // R9 hold with flag update
    wr(3'd0, 16'h004D, 0);
    wr(3'd1, 16'h0033, 0);
    check_state("R9 hold keeps accumulator");

    // R11 control write does not start
    wr(3'd0, 16'h000A, 0);
    check_state("R11 ctrl write no start");

    // R10 clear, bit 7 not writable, zero clear is no-op
    wr(3'd0, 16'h0088, 0);
    check_state("R10 overflow bit not writable");
    wr(3'd0, 16'h0028, 0);
    check_state("R10 clear");
    wr(3'd2, 16'h0077, 0);
    check_state("R10 operand A cleared");
    wr(3'd0, 16'h0008, 0);
    check_state("R10 zero clear no effect");

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [15:0] c;
      c = 16'($urandom() & 32'hDF);
      if (($urandom() % 16) == 0) c[5] = 1'b1;
      wr(3'd0, c, 0);
      check_state("R11 random ctrl");
      for (int k = 0; k < 1 + int'($urandom() % 2); k++) begin
        wr(3'(1 + ($urandom() % 2)), pick($urandom()), ($urandom() % 4) == 0);
        check_state("R6 random operation");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule